// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles whether a conditional branch is taken. Each evaluation takes a 5-bit options field, one condition bit already picked from the condition register, the current count register value and the kind of branch. There are three kinds: relative, through the link register, and through the count register. The options field decides whether the count is decremented and tested and whether the condition bit is tested. The block returns the taken decision, the count value to write back with its write enable, and a static prediction hint. Target address arithmetic and link-register updates are left to the surrounding fetch logic.

Option bits are numbered 0 to 4 from the most significant end, so `in_opt[4]` is bit 0 and `in_opt[0]` is bit 4. Bit 0 set means the condition is ignored. Otherwise bit 1 gives the condition value that lets the branch go. Bit 2 clear asks for a count decrement. In decrement forms, bit 3 selects the count test and bit 4 is the hint. Reserved bits must be zero, and the block flags any encoding that breaks this rule.

A sample is taken on each clock edge where `in_valid` is high. The results appear on the registered outputs one cycle later, marked by `out_valid`.

Top module: `bcond_resolver`

## Requirements
- R1: When bit 0 is 0 and bit 2 is 1, the branch is taken exactly when the condition bit equals bit 1. There is no decrement: `ctr_we`=0 and `next_ctr` equals the input count.
- R2: When bit 0 is 0 and bit 2 is 0, the count is decremented. The branch is taken only when the condition bit equals bit 1 and the count test passes. The test passes for a nonzero decremented count when bit 3 is 0, and for a zero decremented count when bit 3 is 1.
- R3: When bit 0 is 1 and bit 2 is 0, the count is decremented and tested as in R2. The condition bit has no effect on the result.
- R4: When bit 0 is 1 and bit 2 is 1 and the encoding is valid, the branch is always taken and the count is not written.
- R5: The encoding is invalid when a reserved bit is 1. The reserved bits are bit 3 in condition-only forms, bit 1 in decrement-without-condition forms, and bits 1, 3 and 4 in branch-always forms.
- R6: Kind codes are 0 relative, 1 link register, 2 count register and 3 reserved. Kind code 3 is invalid. Kind 2 combined with bit 2 equal to 0 is also invalid.
- R7: An invalid encoding raises `invalid_form`, forces `taken` and `ctr_we` to 0, and returns the input count unchanged on `next_ctr`.
- R8: A valid decrement gives `ctr_we`=1 and `next_ctr` = count − 1 modulo 2^CTR_W, so a count of 0 becomes all ones.
- R9: `hint` equals bit 4 in every form except branch-always, where it is 0. The hint bit never changes `taken`.
- R10: The outputs show the sample from the previous edge that had `in_valid` high. After an edge with `in_valid` low, `out_valid`, `taken` and `ctr_we` are 0.
- R11: During reset, `out_valid`, `taken`, `ctr_we`, `hint`, `invalid_form` and `next_ctr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_opt | input | 5 | Branch options field; bit 0 of the field is in_opt[4] |
| in_cond | input | 1 | Selected condition bit |
| in_kind | input | 2 | Branch kind: 0 relative, 1 link register, 2 count register |
| in_ctr | input | CTR_W | Current count register value |
| out_valid | output | 1 | Registered result is valid |
| taken | output | 1 | Branch is taken |
| next_ctr | output | CTR_W | Count value to write back |
| ctr_we | output | 1 | Count register write enable |
| hint | output | 1 | Static prediction hint |
| invalid_form | output | 1 | Options or kind encoding is invalid |

## Verification
The condition-only forms are run with both condition values and both sense bits. This separates a sense comparison from a plain pass-through of the condition. The decrement forms use counts of 1, 2 and 0. A count of 1 reaches zero after the decrement, a count of 2 does not, and a count of 0 wraps to all ones, so each count-test sense is checked on both sides and a test on the raw count is caught. Each reserved bit is set on its own, and the count-register kind is paired with decrement forms and with non-decrement forms. The same encodings are applied with the hint bit at 0 and at 1, and the condition is flipped in the forms that ignore it, to show that neither input changes the decision.

// File: rtl/bcond_pkg.sv
package bcond_pkg;
  localparam int OPT_W = 5;

  typedef enum logic [1:0] {
    BK_REL = 2'd0,
    BK_LR  = 2'd1,
    BK_CTR = 2'd2,
    BK_RSV = 2'd3
  } bkind_e;

  // Field bit 0 sits at the MSB of the options vector.
  function automatic logic opt_bit(input logic [OPT_W-1:0] opt, input int idx);
    return opt[OPT_W-1-idx];
  endfunction

  function automatic logic [63:0] ctr_minus_one(input logic [63:0] v);
    return v - 64'd1;
  endfunction

  // Count test on the decremented value: zero_sense=1 passes on zero.
  function automatic logic cnt_test(input logic is_zero, input logic zero_sense);
    return zero_sense ? is_zero : !is_zero;
  endfunction
endpackage

// File: rtl/bcond_opt_decode.sv
module bcond_opt_decode
  import bcond_pkg::*;
(
  input  logic [OPT_W-1:0] opt,
  output logic             dec_req,
  output logic             cond_used,
  output logic             cond_sense,
  output logic             zero_sense,
  output logic             always_form,
  output logic             hint,
  output logic             rsv_err
);
  logic b0, b1, b2, b3, b4;

  always_comb begin
    b0 = opt_bit(opt, 0);
    b1 = opt_bit(opt, 1);
    b2 = opt_bit(opt, 2);
    b3 = opt_bit(opt, 3);
    b4 = opt_bit(opt, 4);

    dec_req     = !b2;
    cond_used   = !b0;
    cond_sense  = b1;
    zero_sense  = b3 & !b2;
    always_form = b0 & b2;
    hint        = always_form ? 1'b0 : b4;

    unique case ({b0, b2})
      2'b00:   rsv_err = 1'b0;             // decrement and condition
      2'b01:   rsv_err = b3;               // condition only
      2'b10:   rsv_err = b1;               // decrement only
      default: rsv_err = b1 | b3 | b4;     // always
    endcase
  end
endmodule

// File: rtl/bcond_ctr_eval.sv
module bcond_ctr_eval
  import bcond_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic [CTR_W-1:0] ctr,
  input  logic             dec_req,
  input  logic             zero_sense,
  output logic [CTR_W-1:0] ctr_dec,
  output logic             cnt_hit
);
  logic [63:0] wide;

  always_comb begin
    wide    = ctr_minus_one(64'(ctr));
    ctr_dec = wide[CTR_W-1:0];
    cnt_hit = dec_req ? cnt_test(ctr_dec == '0, zero_sense) : 1'b1;
  end
endmodule

// File: rtl/bcond_resolver.sv
module bcond_resolver
  import bcond_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       in_opt,
  input  logic             in_cond,
  input  logic [1:0]       in_kind,
  input  logic [CTR_W-1:0] in_ctr,
  output logic             out_valid,
  output logic             taken,
  output logic [CTR_W-1:0] next_ctr,
  output logic             ctr_we,
  output logic             hint,
  output logic             invalid_form
);
  // Named internal events, used by the bound checker.
  logic             dec_req, cond_used, cond_sense, zero_sense, always_form;
  logic             hint_c, rsv_err, kind_bad, inv_c;
  logic             cond_hit, cnt_hit, take_c, we_c;
  logic [CTR_W-1:0] ctr_dec, nctr_c;
  bkind_e           kind;

  bcond_opt_decode u_dec (
    .opt        (in_opt),
    .dec_req    (dec_req),
    .cond_used  (cond_used),
    .cond_sense (cond_sense),
    .zero_sense (zero_sense),
    .always_form(always_form),
    .hint       (hint_c),
    .rsv_err    (rsv_err)
  );

  bcond_ctr_eval #(.CTR_W(CTR_W)) u_cnt (
    .ctr        (in_ctr),
    .dec_req    (dec_req),
    .zero_sense (zero_sense),
    .ctr_dec    (ctr_dec),
    .cnt_hit    (cnt_hit)
  );

  always_comb begin
    kind     = bkind_e'(in_kind);
    kind_bad = (kind == BK_RSV) || (kind == BK_CTR && dec_req);
    inv_c    = rsv_err | kind_bad;
    cond_hit = !cond_used || (in_cond == cond_sense) || always_form;
    take_c   = cond_hit && cnt_hit && !inv_c;
    we_c     = dec_req && !inv_c;
    nctr_c   = we_c ? ctr_dec : in_ctr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      taken        <= 1'b0;
      ctr_we       <= 1'b0;
      hint         <= 1'b0;
      invalid_form <= 1'b0;
      next_ctr     <= '0;
    end else if (in_valid) begin
      out_valid    <= 1'b1;
      taken        <= take_c;
      ctr_we       <= we_c;
      hint         <= hint_c;
      invalid_form <= inv_c;
      next_ctr     <= nctr_c;
    end else begin
      out_valid    <= 1'b0;
      taken        <= 1'b0;
      ctr_we       <= 1'b0;
    end
  end
endmodule

// File: rtl/bcond_resolver_chk.sv
module bcond_resolver_chk #(
  parameter int CTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [4:0]       in_opt,
  input logic             in_cond,
  input logic [1:0]       in_kind,
  input logic [CTR_W-1:0] in_ctr,
  input logic             out_valid,
  input logic             taken,
  input logic [CTR_W-1:0] next_ctr,
  input logic             ctr_we,
  input logic             hint,
  input logic             invalid_form,
  input logic             dec_req,
  input logic             inv_c,
  input logic             cond_hit,
  input logic             cnt_hit
);
  p_inv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid_form |-> !taken && !ctr_we && next_ctr == $past(in_ctr));

  p_dec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ctr_we |-> next_ctr == $past(in_ctr) - CTR_W'(1));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !taken && !ctr_we);

  p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_ctr_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == 2'd2 && !in_opt[2] |=> invalid_form);

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opt[4] && in_opt[2] && !in_opt[3] && !in_opt[1] && !in_opt[0]
      && in_kind != 2'd3 |=> taken && !ctr_we);

  p_hint_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opt[4] && in_opt[2] |=> !hint);

  p_cond_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !inv_c && !in_opt[4] && in_opt[2]
      |=> taken == ($past(in_cond) == $past(in_opt[3])) && !ctr_we);

  p_dec_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !inv_c && dec_req |=> ctr_we);

  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !inv_c |=> taken == $past(cond_hit && cnt_hit));
endmodule

bind bcond_resolver bcond_resolver_chk #(.CTR_W(CTR_W)) u_chk (.*);

// File: tb/bcond_resolver_tb.sv
module bcond_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [4:0]   in_opt = '0;
  logic         in_cond = 1'b0;
  logic [1:0]   in_kind = '0;
  logic [W-1:0] in_ctr = '0;
  logic         out_valid, taken, ctr_we, hint, invalid_form;
  logic [W-1:0] next_ctr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcond_resolver #(.CTR_W(W)) u_dut (.*);

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference decision written from the requirements.
  task automatic run(input string req, input logic [4:0] opt, input logic cnd,
                     input logic [1:0] knd, input logic [W-1:0] ctr);
    logic dec, need_c, use_c, zs, alw, inv, h, pass, tk;
    logic [W-1:0] nc;
    dec = 0; use_c = 0; need_c = 0; zs = 0; alw = 0; inv = 0; h = opt[0];
    casez (opt)
      5'b0?0??: begin dec = 1; use_c = 1; need_c = opt[3]; zs = opt[1]; end
      5'b0?1??: begin use_c = 1; need_c = opt[3]; inv = opt[1]; end
      5'b1?0??: begin dec = 1; zs = opt[1]; inv = opt[3]; end
      default:  begin alw = 1; h = 0; inv = opt[3] | opt[1] | opt[0]; end
    endcase
    if (knd == 2'd3) inv = 1;
    if (knd == 2'd2 && dec) inv = 1;
    nc = ctr - 1;
    pass = 1;
    if (use_c && cnd != need_c) pass = 0;
    if (dec && (zs ? (nc != 0) : (nc == 0))) pass = 0;
    tk = pass && !inv;
    if (!dec || inv) nc = ctr;
    @(negedge clk);
    in_valid = 1; in_opt = opt; in_cond = cnd; in_kind = knd; in_ctr = ctr;
    @(negedge clk);
    in_valid = 0;
    check(req, "out_valid", W'(out_valid), W'(1));
    check(req, "taken", W'(taken), W'(tk));
    check(req, "ctr_we", W'(ctr_we), W'(dec && !inv));
    check(req, "next_ctr", next_ctr, nc);
    check(req, "hint", W'(hint), W'(h));
    check(req, "invalid_form", W'(invalid_form), W'(inv));
  endtask

  task automatic t_reset();
    check("R11", "out_valid", W'(out_valid), 0);
    check("R11", "taken", W'(taken), 0);
    check("R11", "ctr_we", W'(ctr_we), 0);
    check("R11", "hint", W'(hint), 0);
    check("R11", "invalid_form", W'(invalid_form), 0);
    check("R11", "next_ctr", next_ctr, 0);
  endtask

  task automatic t_cond_only();  // R1
    for (int c = 0; c < 2; c++) begin
      run("R1", 5'b00100, c[0], 2'd0, 32'd7);
      run("R1", 5'b01100, c[0], 2'd1, 32'd7);
      run("R1", 5'b01101, c[0], 2'd2, 32'd0);
    end
  endtask

  task automatic t_dec_cond();  // R2
    for (int c = 0; c < 2; c++) begin
      run("R2", 5'b00000, c[0], 2'd0, 32'd2);
      run("R2", 5'b00000, c[0], 2'd0, 32'd1);
      run("R2", 5'b00010, c[0], 2'd1, 32'd1);
      run("R2", 5'b01000, c[0], 2'd0, 32'd2);
      run("R2", 5'b01010, c[0], 2'd0, 32'd1);
      run("R2", 5'b01010, c[0], 2'd0, 32'd3);
    end
  endtask

  task automatic t_dec_only();  // R3
    for (int c = 0; c < 2; c++) begin
      run("R3", 5'b10000, c[0], 2'd0, 32'd5);
      run("R3", 5'b10000, c[0], 2'd1, 32'd1);
      run("R3", 5'b10010, c[0], 2'd0, 32'd1);
      run("R3", 5'b10010, c[0], 2'd0, 32'd9);
    end
  endtask

  task automatic t_always();  // R4
    run("R4", 5'b10100, 1'b0, 2'd0, 32'd0);
    run("R4", 5'b10100, 1'b1, 2'd2, 32'd4);
    run("R4", 5'b11100, 1'b0, 2'd1, 32'd4);
  endtask

  task automatic t_reserved();  // R5, R7
    run("R5", 5'b00110, 1'b0, 2'd0, 32'd3);
    run("R5", 5'b01110, 1'b1, 2'd0, 32'd3);
    run("R5", 5'b11000, 1'b0, 2'd0, 32'd3);
    run("R5", 5'b10110, 1'b0, 2'd0, 32'd3);
    run("R5", 5'b10101, 1'b0, 2'd0, 32'd3);
    run("R5", 5'b11100, 1'b0, 2'd0, 32'd3);
    run("R7", 5'b11000, 1'b0, 2'd0, 32'd1);
  endtask

  task automatic t_kind();  // R6
    run("R6", 5'b00000, 1'b0, 2'd2, 32'd5);
    run("R6", 5'b10000, 1'b0, 2'd2, 32'd1);
    run("R6", 5'b01100, 1'b1, 2'd2, 32'd1);
    run("R6", 5'b10100, 1'b0, 2'd3, 32'd1);
  endtask

  task automatic t_hint();  // R9
    run("R9", 5'b00101, 1'b0, 2'd0, 32'd1);
    run("R9", 5'b10001, 1'b0, 2'd0, 32'd5);
    run("R9", 5'b10000, 1'b0, 2'd0, 32'd5);
    run("R9", 5'b01011, 1'b1, 2'd0, 32'd1);
  endtask

  task automatic t_wrap();  // R8
    run("R8", 5'b10000, 1'b0, 2'd0, 32'd0);
    run("R8", 5'b10010, 1'b0, 2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_idle();  // R10
    run("R10", 5'b10100, 1'b0, 2'd0, 32'd8);
    @(negedge clk);
    check("R10", "out_valid idle", W'(out_valid), 0);
    check("R10", "taken idle", W'(taken), 0);
    check("R10", "ctr_we idle", W'(ctr_we), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_cond_only();
    t_dec_cond();
    t_dec_only();
    t_always();
    t_reserved();
    t_kind();
    t_hint();
    t_wrap();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule